// File: doc/BRIEF.md
# Left/Right FIFO Fill Resynchronisation Controller

This block keeps the two halves of a stereo FIFO pair in step. A FIFO pair stores left and right samples in separate queues. An overrun or underrun that hits only one half makes the two fill levels drift apart. The controller watches both fill counts. When it is enabled and active and the counts disagree, it issues a one-cycle load strobe that carries the left fill count. The right FIFO must copy that value into its fill pointer. The controller also latches an interrupt that software clears with an acknowledge.

Each FIFO pair gets its own instance, so correction can be switched on or off per pair. The controller has three states: Off, Stand-By and On. Raising the enable leaves Off and waits in Stand-By. The first valid sample the pair receives after that arms the comparison. Dropping the enable returns the controller to Off from any state.

Top module: `fifo_resync_ctrl`

## Requirements
- R1: The state output is encoded as 0 for Off, 1 for Stand-By and 2 for On; the value 3 never appears. After reset the state is Off and the load strobe and interrupt are low.
- R2: With the enable low at a clock edge, the state is Off after that edge, whatever the state was before. A load strobe only follows an edge at which the state was On and the enable was high.
- R3: In Off, an edge that samples the enable high moves the state to Stand-By.
- R4: In Stand-By with the enable high, an edge that samples the sample-valid input high moves the state to On. Without it, the state stays Stand-By and no correction is issued, even when the fill counts differ.
- R5: In On with the enable high, an edge that samples unequal left and right fill counts makes the load strobe high for the following cycle, with the load value equal to the left fill count sampled at that edge.
- R6: Equal fill counts never produce a load strobe.
- R7: The load strobe is high for one cycle at most. The fill counts are not compared at the edge that ends a strobe cycle, so a persistent mismatch gives a strobe on every second cycle.
- R8: The interrupt goes high together with each load strobe and stays high until an edge samples the acknowledge input high. It then falls after that edge, unless a new correction is issued at the same edge, in which case it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Per-pair resynchronisation enable |
| sampleValid | input | 1 | A valid sample entered the FIFO pair in this cycle |
| leftFill | input | CNT_W | Left FIFO fill count |
| rightFill | input | CNT_W | Right FIFO fill count |
| irqAck | input | 1 | Clears the sticky interrupt |
| loadStrobe | output | 1 | One-cycle command to load the right fill pointer |
| loadValue | output | CNT_W | Value to load into the right fill pointer |
| irq | output | 1 | Sticky correction interrupt |
| state | output | 2 | Current controller state (0 Off, 1 Stand-By, 2 On) |

## Verification
On every cycle, the embedded assertions check the following: the state stays legal, the forced return to Off, the Off-to-Stand-By and Stand-By-to-On steps, the single-cycle strobe, and that a strobe only follows a mismatch seen while On and enabled. They also check that the load value matches the left count sampled at that edge, and how the interrupt rises and clears. Some behaviour only the bench scenarios can show, because there the bench model must agree with the design over whole sequences. This covers the every-second-cycle strobe pattern under a persistent mismatch and mismatches ignored in Stand-By. It also covers the interrupt staying high when an acknowledge meets a new correction, and re-arming after the enable is cycled.

// File: rtl/fifo_resync_pkg.sv
package fifo_resync_pkg;

  typedef enum logic [1:0] {
    RS_OFF     = 2'd0,
    RS_STANDBY = 2'd1,
    RS_ON      = 2'd2
  } rsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic compareEn;   // state On and enable high
    logic clearIrq;    // acknowledge seen
  } rsStrobe_t;

endpackage

// File: rtl/resync_fsm.sv
module resync_fsm
  import fifo_resync_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      sampleValid,
  input  logic      irqAck,
  output rsStrobe_t strobes,
  output logic [1:0] state
);

  rsState_e curState, nextState;

  always_comb begin
    nextState = curState;
    if (!enable) begin
      nextState = RS_OFF;
    end else begin
      unique case (curState)
        RS_OFF:     nextState = RS_STANDBY;
        RS_STANDBY: if (sampleValid) nextState = RS_ON;
        RS_ON:      nextState = RS_ON;
        default:    nextState = RS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= RS_OFF;
    else       curState <= nextState;
  end

  always_comb begin
    strobes.compareEn = (curState == RS_ON) && enable;
    strobes.clearIrq  = irqAck;
  end

  assign state = curState;

  // R1: state encoding stays legal
  a_r1_legal_state: assert property (@(posedge clk) disable iff (!rstN)
    state != 2'd3);

  // R2: disable forces Off
  a_r2_off_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> state == 2'd0);

  // R3: Off steps to Stand-By when enabled
  a_r3_off_to_standby: assert property (@(posedge clk) disable iff (!rstN)
    (state == 2'd0 && enable) |=> state == 2'd1);

  // R4: first valid sample arms the comparison
  a_r4_standby_to_on: assert property (@(posedge clk) disable iff (!rstN)
    (state == 2'd1 && enable && sampleValid) |=> state == 2'd2);

  a_r4_standby_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == 2'd1 && enable && !sampleValid) |=> state == 2'd1);

endmodule

// File: rtl/resync_datapath.sv
module resync_datapath
  import fifo_resync_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  rsStrobe_t        strobes,
  input  logic [CNT_W-1:0] leftFill,
  input  logic [CNT_W-1:0] rightFill,
  output logic             loadStrobe,
  output logic [CNT_W-1:0] loadValue,
  output logic             irq
);

  logic mismatch;
  logic doLoad;

  always_comb begin
    mismatch = (leftFill != rightFill);
    // no compare in the cycle that carries a strobe
    doLoad   = strobes.compareEn && !loadStrobe && mismatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadStrobe <= 1'b0;
      loadValue  <= '0;
      irq        <= 1'b0;
    end else begin
      loadStrobe <= doLoad;
      if (doLoad) loadValue <= leftFill;
      irq <= doLoad | (irq & ~strobes.clearIrq);
    end
  end

  // R7: strobe never lasts two cycles
  a_r7_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !loadStrobe);

  // R5/R6: a strobe follows a sampled mismatch and carries the left count
  a_r6_strobe_needs_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> $past(leftFill != rightFill));

  a_r5_load_value: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> loadValue == $past(leftFill));

  // R8: interrupt rises only with a correction, acknowledge clears it
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> loadStrobe);

  a_r8_strobe_sets_irq: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> irq);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearIrq |=> (loadStrobe || !irq));

endmodule

// File: rtl/fifo_resync_ctrl.sv
module fifo_resync_ctrl
  import fifo_resync_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             sampleValid,
  input  logic [CNT_W-1:0] leftFill,
  input  logic [CNT_W-1:0] rightFill,
  input  logic             irqAck,
  output logic             loadStrobe,
  output logic [CNT_W-1:0] loadValue,
  output logic             irq,
  output logic [1:0]       state
);

  rsStrobe_t strobes;

  resync_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .sampleValid (sampleValid),
    .irqAck      (irqAck),
    .strobes     (strobes),
    .state       (state)
  );

  resync_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .leftFill   (leftFill),
    .rightFill  (rightFill),
    .loadStrobe (loadStrobe),
    .loadValue  (loadValue),
    .irq        (irq)
  );

  // R2: a strobe only follows an edge in On with enable high
  a_r2_strobe_only_from_on: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> ($past(state) == 2'd2 && $past(enable)));

endmodule

// File: tb/fifo_resync_ctrl_test.sv
`timescale 1ns/1ps
module fifo_resync_ctrl_test;

  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             sampleValid = 1'b0;
  logic [CNT_W-1:0] leftFill = '0;
  logic [CNT_W-1:0] rightFill = '0;
  logic             irqAck = 1'b0;
  logic             loadStrobe;
  logic [CNT_W-1:0] loadValue;
  logic             irq;
  logic [1:0]       state;

  always #4 clk = ~clk;  // 125 MHz

  fifo_resync_ctrl #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleValid(sampleValid),
    .leftFill(leftFill), .rightFill(rightFill), .irqAck(irqAck),
    .loadStrobe(loadStrobe), .loadValue(loadValue), .irq(irq), .state(state)
  );

  int    tests = 0;
  int    fails = 0;
  string tag = "R1";
  bit    finished = 1'b0;

  // behavioural reference model
  int mState = 0;
  bit mStrobe = 0;
  int mValue = 0;
  bit mIrq = 0;

  always @(posedge clk) begin
    bit nStrobe;
    if (!rstN) begin
      mState  <= 0;
      mStrobe <= 0;
      mValue  <= 0;
      mIrq    <= 0;
    end else begin
      nStrobe = (mState == 2) && enable && !mStrobe && (leftFill != rightFill);
      mStrobe <= nStrobe;
      if (nStrobe) mValue <= int'(leftFill);
      mIrq <= nStrobe || (mIrq && !irqAck);
      if (!enable)                       mState <= 0;
      else if (mState == 0)              mState <= 1;
      else if (mState == 1 && sampleValid) mState <= 2;
    end
  end

  task automatic check(string t, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  // compare with the model on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(tag, "state", int'(state), mState);
      check(tag, "loadStrobe", int'(loadStrobe), int'(mStrobe));
      check(tag, "irq", int'(irq), int'(mIrq));
      if (mStrobe) check(tag, "loadValue", int'(loadValue), mValue);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1: reset state
    check("R1", "reset state", int'(state), 0);
    check("R1", "reset strobe", int'(loadStrobe), 0);
    check("R1", "reset irq", int'(irq), 0);

    // R3 / R4: enable, wait in Stand-By with a mismatch present
    tag = "R3";
    enable = 1'b1; leftFill = 4'd5; rightFill = 4'd2;
    step(1);
    check("R3", "standby after enable", int'(state), 1);
    tag = "R4";
    step(4);
    check("R4", "still standby", int'(state), 1);
    check("R4", "no strobe in standby", int'(loadStrobe), 0);

    // R6: arm with equal fills
    leftFill = 4'd3; rightFill = 4'd3;
    sampleValid = 1'b1;
    step(1);
    sampleValid = 1'b0;
    check("R4", "on after sample", int'(state), 2);
    tag = "R6";
    step(5);
    check("R6", "equal no strobe", int'(loadStrobe), 0);

    // R5: single-cycle mismatch
    tag = "R5";
    leftFill = 4'd9; rightFill = 4'd7;
    step(1);
    leftFill = 4'd9; rightFill = 4'd9;
    check("R5", "strobe after mismatch", int'(loadStrobe), 1);
    check("R5", "load value", int'(loadValue), 9);
    step(1);
    check("R7", "strobe one cycle", int'(loadStrobe), 0);
    check("R8", "irq sticky", int'(irq), 1);
    step(3);
    check("R8", "irq still set", int'(irq), 1);

    // R8: acknowledge clears
    tag = "R8";
    irqAck = 1'b1;
    step(1);
    irqAck = 1'b0;
    check("R8", "irq cleared", int'(irq), 0);

    // R7: persistent mismatch, extreme values
    tag = "R7";
    leftFill = 4'd15; rightFill = 4'd0;
    step(1);
    check("R7", "first strobe", int'(loadStrobe), 1);
    check("R5", "value 15", int'(loadValue), 15);
    step(1);
    check("R7", "gap cycle", int'(loadStrobe), 0);
    step(1);
    check("R7", "second strobe", int'(loadStrobe), 1);
    leftFill = 4'd0; rightFill = 4'd15;
    step(1);
    step(1);
    check("R5", "value 0", int'(loadValue), 0);
    check("R7", "third strobe", int'(loadStrobe), 1);

    // R8: acknowledge meeting a new correction keeps irq high
    tag = "R8";
    step(1);          // gap cycle, mismatch persists
    irqAck = 1'b1;    // next edge both compares and acknowledges
    step(1);
    irqAck = 1'b0;
    check("R8", "set wins over ack", int'(irq), 1);
    check("R8", "strobe with ack", int'(loadStrobe), 1);
    leftFill = 4'd6; rightFill = 4'd6;
    irqAck = 1'b1;
    step(1);
    irqAck = 1'b0;
    check("R8", "ack clears", int'(irq), 0);

    // R2: dropping enable with a mismatch present
    tag = "R2";
    leftFill = 4'd4; rightFill = 4'd1;
    enable = 1'b0;
    step(1);
    check("R2", "off after disable", int'(state), 0);
    check("R2", "no strobe when disabled", int'(loadStrobe), 0);
    step(3);
    check("R2", "off holds no strobe", int'(loadStrobe), 0);

    // re-arm: Off -> Stand-By -> On with mismatch
    tag = "R3";
    enable = 1'b1;
    step(1);
    check("R3", "standby again", int'(state), 1);
    tag = "R4";
    sampleValid = 1'b1;
    step(1);
    sampleValid = 1'b0;
    tag = "R5";
    step(1);
    check("R5", "strobe after rearm", int'(loadStrobe), 1);
    check("R5", "value 4", int'(loadValue), 4);

    // R2: disable from Stand-By
    tag = "R2";
    enable = 1'b0;
    step(1);
    enable = 1'b1;
    step(1);
    check("R2", "standby after cycle", int'(state), 1);
    enable = 1'b0;
    step(1);
    check("R2", "off from standby", int'(state), 0);
    step(2);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule